// File: doc/BRIEF.md
# IR Pulse-Width Classifier and Bit Assembler

This block sits behind the noise filter of an infrared receiver. It counts sample ticks between successive measuring edges of the cleaned-up signal with an 11-bit interval timer. Each finished interval is sorted into one of five pulse classes: leader (header), zero bit, one bit, special marker, or frame end. The zero and one classes are turned into data bits and packed LSB first into a 64-bit receive store. The store is exposed as two 32-bit words.

The edge strobes, the sample tick and all programmable settings come in as plain inputs from surrounding logic: window bounds, edge mode, bit-count compare, error bypass and the clear commands. The block reports the two data words, the running bit count, the last latched interval and a vector of sticky event flags. Register decoding and interrupt merging are left to the surrounding logic.

Top module: `ir_pulse_decoder`

## Requirements
- R1: Each of the four windows (flags_o index 0 leader, 1 zero, 2 one, 3 special) matches when its low bound ≤ interval ≤ its high bound, both ends inclusive. A window whose two bounds are both zero never matches. When several windows match, the lowest index wins. win_lo_i and win_hi_i carry window w in bits [w*11 +: 11].
- R2: An interval that matches no window, with end_lo_i nonzero and interval ≥ end_lo_i, sets the end flag (index 4). It also ends the frame: a new leader is needed before bits are stored again, and the next measuring edge only restarts the timer.
- R3: edge_mode_i selects the measuring edge. 0 uses rise_i, 1 uses fall_i, 2 uses rise_i and stores data bits without a leader, and 3 measures nothing. Strobes of the unselected edge are ignored. The first measuring edge after enable, after an end match or after an overflow only starts timing.
- R4: interval_o takes the measured interval whenever a leader, zero, one or special match or an error is flagged. On a timer overflow it takes 2047.
- R5: Outside mode 2, a zero or one match after a leader stores 0 or 1 at the bit position equal to the bit count. Positions 0 to 31 go to word0_o and positions 32 to 63 go to word1_o. The count then increments. Zero or one matches without a leader store nothing.
- R6: The bit count stops at 64. Reaching 64 sets the buffer-full flag (index 5), and further bits change neither the count nor the words.
- R7: With bitcmp_en_i high, a bit count equal to bitcmp_val_i sets the bit-match flag (index 8).
- R8: An interval matching no window and no end pattern, or a timer overflow past 2047 ticks while timing, sets the error flag (index 7).
- R9: While the error flag is set and err_bypass_i is 0, zero and one matches store nothing. With err_bypass_i at 1, storing continues.
- R10: A 0-to-1 change of enable_i clears all flags and the timer. It also clears the bit count, using the same busy sequence as R11.
- R11: A cnt_clr_i pulse raises clr_busy_o in the next cycle. The cycle after that, the count reads 0 and clr_busy_o is low.
- R12: Flags are sticky. A 1 on a flag_clr_i bit clears that flag, and a set event in the same cycle wins over the clear.
- R13: word_clr_i clears both data words only while enable_i is 0. While enabled, it is ignored.
- R14: The data-received flag (index 6) sets whenever a bit is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| enable_i | input | 1 | Receiver enable; its rising edge restarts the block |
| sample_tick_i | input | 1 | Timer advance strobe |
| rise_i | input | 1 | Rising-edge strobe of the filtered input |
| fall_i | input | 1 | Falling-edge strobe of the filtered input |
| edge_mode_i | input | 2 | Measuring edge / format select |
| win_lo_i | input | 44 | Low bounds of the four windows |
| win_hi_i | input | 44 | High bounds of the four windows |
| end_lo_i | input | 11 | Minimum interval of the end pattern |
| bitcmp_en_i | input | 1 | Bit-count compare enable |
| bitcmp_val_i | input | 7 | Bit-count compare value (0..64) |
| err_bypass_i | input | 1 | Keep storing bits while the error flag is set |
| flag_clr_i | input | 9 | Write-1-to-clear strobes for the flags |
| cnt_clr_i | input | 1 | Bit-count clear request |
| word_clr_i | input | 1 | Data-word clear, honoured only while disabled |
| word0_o | output | 32 | Receive bits 0..31 |
| word1_o | output | 32 | Receive bits 32..63 |
| bit_count_o | output | 7 | Number of stored bits |
| interval_o | output | 11 | Latched interval |
| flags_o | output | 9 | Sticky event flags |
| clr_busy_o | output | 1 | Bit-count clear in progress |

## Verification
Each edge strobe is sampled by one register stage. Its class flag, latched interval, stored bit and new count are therefore due at the first falling clock edge after the sampling rising edge. The bench drives strobes on falling edges and checks at the falling edge where its pulse task returns. The bit-match flag compares the already registered count, so it is checked one cycle later. A clear request shows clr_busy_o one cycle after it and a zero count the cycle after that. Both are checked on consecutive falling edges. Interval targets are placed by counting rising edges since the last measuring edge, so the flag-clear cycles in between do not shift the measured values.

// File: rtl/irdec_pkg.sv
package irdec_pkg;

    localparam int FLAG_W   = 9;
    localparam int F_HDR    = 0;
    localparam int F_ZERO   = 1;
    localparam int F_ONE    = 2;
    localparam int F_SPEC   = 3;
    localparam int F_END    = 4;
    localparam int F_FULL   = 5;
    localparam int F_RX     = 6;
    localparam int F_ERR    = 7;
    localparam int F_BITM   = 8;

    localparam int NUM_WIN  = 4;

    typedef enum logic [1:0] {
        MODE_RISE = 2'd0,
        MODE_FALL = 2'd1,
        MODE_FLEX = 2'd2,
        MODE_OFF  = 2'd3
    } edge_mode_e;

endpackage

// File: rtl/irdec_interval_timer.sv
module irdec_interval_timer
    import irdec_pkg::*;
#(
    parameter int TW = 11
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          enable_i,
    input  logic          restart_i,
    input  logic          tick_i,
    input  logic          rise_i,
    input  logic          fall_i,
    input  edge_mode_e    mode_i,
    input  logic          end_hit_i,
    output logic          meas_evt_o,
    output logic [TW-1:0] meas_val_o,
    output logic          ovf_evt_o
);
    localparam logic [TW-1:0] TMAX = '1;

    typedef struct packed {
        logic [TW-1:0] timer;
        logic          armed;
    } tstate_t;

    tstate_t s_q, s_d;
    logic    edge_sel;

    always_comb begin
        case (mode_i)
            MODE_RISE, MODE_FLEX: edge_sel = rise_i;
            MODE_FALL:            edge_sel = fall_i;
            default:              edge_sel = 1'b0;
        endcase

        s_d        = s_q;
        meas_evt_o = 1'b0;
        ovf_evt_o  = 1'b0;

        if (restart_i) begin
            s_d = '0;
        end else if (enable_i) begin
            if (edge_sel) begin
                meas_evt_o = s_q.armed;
                s_d.timer  = '0;
                s_d.armed  = 1'b1;
            end else if (tick_i) begin
                if (s_q.timer == TMAX) begin
                    ovf_evt_o = s_q.armed;
                    s_d.armed = 1'b0;
                end else begin
                    s_d.timer = s_q.timer + 1'b1;
                end
            end
            if (end_hit_i) s_d.armed = 1'b0;
        end
    end

    assign meas_val_o = s_q.timer;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R3: a selected edge restarts the interval count from zero
    assert_timer_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !restart_i && edge_sel) |=> (s_q.timer == '0));

endmodule

// File: rtl/irdec_window_classifier.sv
module irdec_window_classifier #(
    parameter int TW   = 11,
    parameter int NWIN = 4
) (
    input  logic [NWIN*TW-1:0] lo_i,
    input  logic [NWIN*TW-1:0] hi_i,
    input  logic [TW-1:0]      end_lo_i,
    input  logic [TW-1:0]      val_i,
    output logic [NWIN:0]      sel_o
);
    logic [NWIN:0] raw;

    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            logic [TW-1:0] lo, hi;
            assign lo     = lo_i[w*TW +: TW];
            assign hi     = hi_i[w*TW +: TW];
            assign raw[w] = ((lo != '0) || (hi != '0)) && (val_i >= lo) && (val_i <= hi);
        end
    endgenerate

    assign raw[NWIN] = (end_lo_i != '0) && (val_i >= end_lo_i);

    always_comb begin
        logic found;
        found = 1'b0;
        sel_o = '0;
        for (int i = 0; i <= NWIN; i++) begin
            if (raw[i] && !found) begin
                sel_o[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irdec_bit_store.sv
module irdec_bit_store #(
    parameter int WORD_W = 32,
    parameter int TOTAL  = 2 * WORD_W,
    parameter int CW     = $clog2(TOTAL + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_req_i,
    input  logic             bit_valid_i,
    input  logic             bit_val_i,
    input  logic             word_clr_i,
    output logic [TOTAL-1:0] store_o,
    output logic [CW-1:0]    count_o,
    output logic             busy_o,
    output logic             stored_o,
    output logic             full_evt_o
);
    localparam int IW = $clog2(TOTAL);
    localparam logic [CW-1:0] CMAX = CW'(TOTAL);

    typedef struct packed {
        logic [TOTAL-1:0] store;
        logic [CW-1:0]    count;
        logic             busy;
    } bstate_t;

    bstate_t s_q, s_d;

    always_comb begin
        s_d        = s_q;
        stored_o   = 1'b0;
        full_evt_o = 1'b0;

        if (word_clr_i) s_d.store = '0;

        if (s_q.busy) begin
            s_d.count = '0;
            s_d.busy  = 1'b0;
        end

        if (clr_req_i) begin
            s_d.busy = 1'b1;
        end else if (!s_q.busy && bit_valid_i && (s_q.count < CMAX)) begin
            s_d.store[s_q.count[IW-1:0]] = bit_val_i;
            s_d.count  = s_q.count + 1'b1;
            stored_o   = 1'b1;
            full_evt_o = (s_q.count == CMAX - 1'b1);
        end
    end

    assign store_o = s_q.store;
    assign count_o = s_q.count;
    assign busy_o  = s_q.busy;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assert_count_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.count <= CMAX);

    assert_count_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s_q.busy && !clr_req_i && bit_valid_i && (s_q.count < CMAX))
        |=> (s_q.count == $past(s_q.count) + 1'b1));

    assert_busy_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.busy && !clr_req_i) |=> (s_q.count == '0 && !s_q.busy));

endmodule

// File: rtl/ir_pulse_decoder.sv
module ir_pulse_decoder
    import irdec_pkg::*;
#(
    parameter int TIME_W = 11,
    parameter int WORD_W = 32,
    parameter int CNT_W  = $clog2(2 * WORD_W + 1)
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       enable_i,
    input  logic                       sample_tick_i,
    input  logic                       rise_i,
    input  logic                       fall_i,
    input  logic [1:0]                 edge_mode_i,
    input  logic [NUM_WIN*TIME_W-1:0]  win_lo_i,
    input  logic [NUM_WIN*TIME_W-1:0]  win_hi_i,
    input  logic [TIME_W-1:0]          end_lo_i,
    input  logic                       bitcmp_en_i,
    input  logic [CNT_W-1:0]           bitcmp_val_i,
    input  logic                       err_bypass_i,
    input  logic [FLAG_W-1:0]          flag_clr_i,
    input  logic                       cnt_clr_i,
    input  logic                       word_clr_i,
    output logic [WORD_W-1:0]          word0_o,
    output logic [WORD_W-1:0]          word1_o,
    output logic [CNT_W-1:0]           bit_count_o,
    output logic [TIME_W-1:0]          interval_o,
    output logic [FLAG_W-1:0]          flags_o,
    output logic                       clr_busy_o
);
    localparam int TOTAL = 2 * WORD_W;

    typedef struct packed {
        logic              en_prev;
        logic              hdr_seen;
        logic [FLAG_W-1:0] flags;
        logic [TIME_W-1:0] interval;
    } top_state_t;

    top_state_t s_q, s_d;

    edge_mode_e        mode;
    logic              en_rise;
    logic              meas_evt, ovf_evt, end_hit;
    logic [TIME_W-1:0] meas_val;
    logic [NUM_WIN:0]  sel;
    logic              hit_hdr, hit_zero, hit_one, hit_spec, err_now;
    logic              bit_valid, stored, full_evt, busy;
    logic [TOTAL-1:0]  store;
    logic [CNT_W-1:0]  count;

    assign mode    = edge_mode_e'(edge_mode_i);
    assign en_rise = enable_i && !s_q.en_prev;

    irdec_interval_timer #(.TW(TIME_W)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable_i),
        .restart_i  (en_rise),
        .tick_i     (sample_tick_i),
        .rise_i     (rise_i),
        .fall_i     (fall_i),
        .mode_i     (mode),
        .end_hit_i  (end_hit),
        .meas_evt_o (meas_evt),
        .meas_val_o (meas_val),
        .ovf_evt_o  (ovf_evt)
    );

    irdec_window_classifier #(.TW(TIME_W), .NWIN(NUM_WIN)) u_class (
        .lo_i     (win_lo_i),
        .hi_i     (win_hi_i),
        .end_lo_i (end_lo_i),
        .val_i    (meas_val),
        .sel_o    (sel)
    );

    irdec_bit_store #(.WORD_W(WORD_W), .TOTAL(TOTAL), .CW(CNT_W)) u_store (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_req_i   (cnt_clr_i || en_rise),
        .bit_valid_i (bit_valid),
        .bit_val_i   (hit_one),
        .word_clr_i  (word_clr_i && !enable_i),
        .store_o     (store),
        .count_o     (count),
        .busy_o      (busy),
        .stored_o    (stored),
        .full_evt_o  (full_evt)
    );

    always_comb begin
        hit_hdr   = meas_evt && sel[0];
        hit_zero  = meas_evt && sel[1];
        hit_one   = meas_evt && sel[2];
        hit_spec  = meas_evt && sel[3];
        end_hit   = meas_evt && sel[NUM_WIN];
        err_now   = (meas_evt && (sel == '0)) || ovf_evt;
        bit_valid = (hit_zero || hit_one)
                    && (s_q.hdr_seen || mode == MODE_FLEX)
                    && !(s_q.flags[F_ERR] && !err_bypass_i);

        s_d         = s_q;
        s_d.en_prev = enable_i;

        if (en_rise) begin
            s_d.flags    = '0;
            s_d.hdr_seen = 1'b0;
        end else begin
            s_d.flags = s_q.flags & ~flag_clr_i;
            if (hit_hdr)  s_d.flags[F_HDR]  = 1'b1;
            if (hit_zero) s_d.flags[F_ZERO] = 1'b1;
            if (hit_one)  s_d.flags[F_ONE]  = 1'b1;
            if (hit_spec) s_d.flags[F_SPEC] = 1'b1;
            if (end_hit)  s_d.flags[F_END]  = 1'b1;
            if (full_evt) s_d.flags[F_FULL] = 1'b1;
            if (stored)   s_d.flags[F_RX]   = 1'b1;
            if (err_now)  s_d.flags[F_ERR]  = 1'b1;
            if (bitcmp_en_i && enable_i && !busy && (count == bitcmp_val_i))
                s_d.flags[F_BITM] = 1'b1;

            if (hit_hdr)              s_d.hdr_seen = 1'b1;
            if (end_hit || ovf_evt)   s_d.hdr_seen = 1'b0;

            if (hit_hdr || hit_zero || hit_one || hit_spec || err_now)
                s_d.interval = meas_val;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign word0_o     = store[WORD_W-1:0];
    assign word1_o     = store[TOTAL-1:WORD_W];
    assign bit_count_o = count;
    assign interval_o  = s_q.interval;
    assign flags_o     = s_q.flags;
    assign clr_busy_o  = busy;

    generate
        for (genvar f = 0; f < FLAG_W; f++) begin : g_sticky
            assert_flag_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (s_q.flags[f] && !flag_clr_i[f] && !en_rise) |=> s_q.flags[f]);
        end
    endgenerate

    assert_drop_on_error_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.flags[F_ERR] && !err_bypass_i && !cnt_clr_i && !en_rise && !busy)
        |=> $stable(count));

    assert_enable_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_rise |=> (s_q.flags == '0 && busy));

endmodule

// File: tb/sim_ir_pulse_decoder.sv
`timescale 1ns/1ps
module sim_ir_pulse_decoder;

    localparam int FH = 0, FZ = 1, FO = 2, FS = 3, FE = 4, FF = 5, FR = 6, FX = 7, FB = 8;
    localparam logic [63:0] PAT = 64'h8E3A_51C7_0F69_D2B4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, tick = 1'b1, rise = 1'b0, fall = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [43:0] wlo, whi;
    logic [10:0] end_lo = 11'd100;
    logic        cmp_en = 1'b0, bypass = 1'b0, cnt_clr = 1'b0, word_clr = 1'b0;
    logic [6:0]  cmp_val = 7'd0;
    logic [8:0]  fclr = '0;
    logic [31:0] w0, w1;
    logic [6:0]  cnt;
    logic [10:0] ivl;
    logic [8:0]  flg;
    logic        busy;

    int checks = 0, failures = 0, cyc = 0, last = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ir_pulse_decoder u0 (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .sample_tick_i(tick),
        .rise_i(rise), .fall_i(fall), .edge_mode_i(mode), .win_lo_i(wlo), .win_hi_i(whi),
        .end_lo_i(end_lo), .bitcmp_en_i(cmp_en), .bitcmp_val_i(cmp_val),
        .err_bypass_i(bypass), .flag_clr_i(fclr), .cnt_clr_i(cnt_clr), .word_clr_i(word_clr),
        .word0_o(w0), .word1_o(w1), .bit_count_o(cnt), .interval_o(ivl),
        .flags_o(flg), .clr_busy_o(busy)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_windows(input bit spec_on);
        wlo = {spec_on ? 11'd25 : 11'd0, 11'd15, 11'd5, 11'd40};
        whi = {spec_on ? 11'd30 : 11'd0, 11'd19, 11'd9, 11'd60};
    endtask

    task automatic arm(input bit use_fall);
        @(negedge clk);
        if (use_fall) fall = 1'b1; else rise = 1'b1;
        last = cyc + 1;
        @(negedge clk);
        rise = 1'b0; fall = 1'b0;
    endtask

    task automatic pulse(input int iv, input bit use_fall, input bit moves);
        while (cyc < last + iv) @(negedge clk);
        if (use_fall) fall = 1'b1; else rise = 1'b1;
        if (moves) last = cyc + 1;
        @(negedge clk);
        rise = 1'b0; fall = 1'b0;
    endtask

    task automatic clr_flags();
        @(negedge clk); fclr = '1;
        @(negedge clk); fclr = '0;
    endtask

    task automatic t_reset();
        chk("R10", "reset flags", flg, 0);
        chk("R5", "reset count", cnt, 0);
        chk("R5", "reset word0", w0, 0);
        chk("R11", "reset busy", busy, 0);
    endtask

    task automatic t_enable();
        @(negedge clk); enable = 1'b1;
        @(negedge clk);
        chk("R10", "busy after enable", busy, 1);
        @(negedge clk);
        chk("R10", "busy done", busy, 0);
        chk("R10", "count zero", cnt, 0);
    endtask

    task automatic t_frame();
        arm(0);
        chk("R3", "first edge only arms", flg, 0);
        pulse(50, 0, 1);
        chk("R1", "leader flag", flg[FH], 1);
        chk("R4", "leader interval", ivl, 50);
        pulse(17, 0, 1); pulse(7, 0, 1); pulse(15, 0, 1); pulse(19, 0, 1);
        pulse(9, 0, 1); pulse(5, 0, 1);
        chk("R5", "word0 lsb first", w0, 32'h0000_000D);
        chk("R5", "count", cnt, 6);
        chk("R1", "zero and one flags (inclusive bounds)", {flg[FO], flg[FZ]}, 2'b11);
        chk("R14", "rx flag", flg[FR], 1);
        chk("R4", "interval of last bit", ivl, 5);
    endtask

    task automatic t_end();
        pulse(120, 0, 1);
        chk("R2", "end flag", flg[FE], 1);
        pulse(3, 0, 1);
        pulse(17, 0, 1);
        chk("R2", "no store after end", cnt, 6);
        chk("R2", "word0 unchanged", w0, 32'h0000_000D);
        chk("R8", "no error from arming edge", flg[FX], 0);
    endtask

    task automatic t_w1c();
        clr_flags();
        chk("R12", "flags cleared by write-one", flg, 0);
        @(negedge clk);
        chk("R12", "flags stay clear", flg, 0);
    endtask

    task automatic t_err();
        pulse(50, 0, 1);
        pulse(35, 0, 1);
        chk("R8", "unmatched interval error", flg[FX], 1);
        chk("R4", "error interval", ivl, 35);
        pulse(17, 0, 1);
        chk("R9", "bit dropped on error", cnt, 6);
        bypass = 1'b1;
        pulse(17, 0, 1);
        chk("R9", "bit kept with bypass", cnt, 7);
        chk("R9", "word0 with bypass bit", w0, 32'h0000_004D);
        bypass = 1'b0;
    endtask

    task automatic t_window_off();
        set_windows(0);
        clr_flags();
        pulse(27, 0, 1);
        chk("R1", "zeroed window no match", flg[FS], 0);
        chk("R8", "zeroed window gives error", flg[FX], 1);
        set_windows(1);
        clr_flags();
        pulse(27, 0, 1);
        chk("R1", "special match", flg[FS], 1);
        chk("R8", "no error on special", flg[FX], 0);
    endtask

    task automatic t_cmp();
        cmp_val = 7'd8; cmp_en = 1'b1;
        @(negedge clk);
        chk("R7", "no match before", flg[FB], 0);
        pulse(7, 0, 1);
        chk("R7", "count reached", cnt, 8);
        @(negedge clk);
        chk("R7", "bit match flag", flg[FB], 1);
        cmp_en = 1'b0;
    endtask

    task automatic t_ovf();
        clr_flags();
        repeat (2060) @(negedge clk);
        chk("R8", "overflow error", flg[FX], 1);
        chk("R4", "overflow interval", ivl, 2047);
    endtask

    task automatic t_clr();
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
        chk("R11", "busy high", busy, 1);
        @(negedge clk);
        chk("R11", "busy low", busy, 0);
        chk("R11", "count cleared", cnt, 0);
    endtask

    task automatic t_flex();
        mode = 2'd2;
        clr_flags();
        arm(0);
        for (int i = 0; i < 64; i++) pulse(PAT[i] ? 17 : 7, 0, 1);
        chk("R5", "flex word0", w0, PAT[31:0]);
        chk("R5", "flex word1", w1, PAT[63:32]);
        chk("R6", "count at cap", cnt, 64);
        chk("R6", "full flag", flg[FF], 1);
        chk("R3", "flex mode stores without leader", flg[FR], 1);
        pulse(17, 0, 1);
        chk("R6", "count held", cnt, 64);
        chk("R6", "word1 held", w1, PAT[63:32]);
    endtask

    task automatic t_fall();
        mode = 2'd1;
        pulse(20, 1, 1);
        clr_flags();
        pulse(20, 0, 0);
        chk("R3", "rise ignored in fall mode", flg, 0);
        pulse(50, 1, 1);
        chk("R3", "fall-to-fall leader", flg[FH], 1);
        chk("R3", "fall interval", ivl, 50);
    endtask

    task automatic t_word_clr();
        @(negedge clk); word_clr = 1'b1;
        @(negedge clk); word_clr = 1'b0;
        chk("R13", "word clear ignored when enabled", w1, PAT[63:32]);
        enable = 1'b0;
        @(negedge clk); word_clr = 1'b1;
        @(negedge clk); word_clr = 1'b0;
        chk("R13", "word0 cleared", w0, 0);
        chk("R13", "word1 cleared", w1, 0);
        enable = 1'b1;
        @(negedge clk);
        chk("R10", "re-enable clears flags", flg, 0);
        chk("R10", "re-enable busy", busy, 1);
        @(negedge clk);
        chk("R10", "re-enable count", cnt, 0);
    endtask

    initial begin
        set_windows(1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_frame();
        t_end();
        t_w1c();
        t_err();
        t_window_off();
        t_cmp();
        t_ovf();
        t_clr();
        t_flex();
        t_fall();
        t_word_clr();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule